// File: doc/BRIEF.md
# Static LCD Hex Counter Driver

This block drives one digit of a static, direct-drive seven-segment liquid-crystal display. The digit shows a four-bit counter that advances on its own, once per second with the default parameters. All timing comes from a single fast system clock with a synchronous, active-high reset.

A prescaler divides the clock into a backplane square wave, 40 Hz from an 80 MHz clock by default. The backplane's half-period ticks then feed two further counters. One steps the displayed digit. The other toggles a status LED that blinks at about 1 Hz. A combinational encoder turns the next digit value into an active-high segment pattern. That pattern is XORed with the next backplane level and registered on the same edge as the backplane itself. A lit segment therefore always runs in antiphase with the backplane, and a dark segment runs in phase with it, so the glass never sees a DC voltage.

The three terminal counts are parameters. A bench can therefore shrink the periods to a few clocks.

Top module: `lcd_hex_driver`

## Requirements
- R1: `bp_o` is a square wave that changes level exactly once every `BP_HALF_CYC` clock cycles and at no other time. The default of 1,000,000 gives 40 Hz from 80 MHz.
- R2: In every cycle, `seg_o` equals the active-high pattern of the displayed digit XORed bitwise with `bp_o`. On every rising edge of `bp_o`, all seven segment outputs invert.
- R3: The active-high pattern uses bit 0 = segment a through bit 6 = segment g. The values, in hex, are: 0→3F, 1→06, 2→5B, 3→4F, 4→66, 5→6D, 6→7D, 7→07, 8→7F, 9→6F, A→77, b→7C, C→39, d→5E, E→79, F→71.
- R4: The displayed digit rises by one every `STEP_HALVES` backplane half-periods. The step falls on the same clock edge as a backplane change. `STEP_HALVES` must be even. The default of 80 gives one step per second.
- R5: After F, the displayed digit wraps to 0.
- R6: `led_o` toggles every `LED_HALVES` backplane half-periods, on an edge where `bp_o` also changes. The default of 40 gives a 1 Hz blink.
- R7: While `rst_i` is high, each clock edge sets `bp_o` to 0, `led_o` to 0 and `seg_o` to 3F, and clears all counters. Timing after release restarts from zero, with the digit showing 0.
- R8: `seg_o` changes only on clock edges where `bp_o` also changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (80 MHz by default) |
| rst_i | input | 1 | Synchronous reset, active high |
| bp_o | output | 1 | Backplane square wave, straight from a flip-flop |
| seg_o | output | 7 | Segment drives a..g (bit 0 = a), each being the pattern XOR backplane, registered |
| led_o | output | 1 | Blinking status LED |

## Verification
The bound checker watches four relations on every cycle: the backplane's half-period length, the full inversion of the segments on each backplane rise, the rule that the segments and the LED move only with the backplane, and the values left by reset. The checker never sees the digit, so only the bench's run can show the full 0-to-F pattern table, the step rate, the F-to-0 wrap and the LED's blink period. The bench checks these against a model that works out every expected output from the number of clock edges since reset, including after a reset in the middle of a run.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int SEGS = 7;
  localparam int DIGIT_W = 4;
  typedef logic [SEGS-1:0]    seg_t;
  typedef logic [DIGIT_W-1:0] digit_t;
  // Pattern shown for digit 0 with the backplane low.
  localparam seg_t SEG_AT_RESET = 7'h3F;
endpackage

// File: rtl/lcd_term_counter.sv
// Counts enabled cycles modulo TERM and pulses wrap_o in the last one.
module lcd_term_counter #(
  parameter int TERM = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic wrap_o
);
  localparam int W = (TERM > 1) ? $clog2(TERM) : 1;
  localparam logic [W-1:0] LAST = W'(TERM - 1);

  logic [W-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_hex_encoder.sv
// Hex digit to active-high segment pattern, bit 0 = segment a.
module lcd_hex_encoder
  import lcd_pkg::*;
(
  input  digit_t digit_i,
  output seg_t   pat_o
);
  always_comb begin
    unique case (digit_i)
      4'h0: pat_o = 7'h3F;
      4'h1: pat_o = 7'h06;
      4'h2: pat_o = 7'h5B;
      4'h3: pat_o = 7'h4F;
      4'h4: pat_o = 7'h66;
      4'h5: pat_o = 7'h6D;
      4'h6: pat_o = 7'h7D;
      4'h7: pat_o = 7'h07;
      4'h8: pat_o = 7'h7F;
      4'h9: pat_o = 7'h6F;
      4'hA: pat_o = 7'h77;
      4'hB: pat_o = 7'h7C;
      4'hC: pat_o = 7'h39;
      4'hD: pat_o = 7'h5E;
      4'hE: pat_o = 7'h79;
      default: pat_o = 7'h71;
    endcase
  end
endmodule

// File: rtl/lcd_hex_driver.sv
module lcd_hex_driver
  import lcd_pkg::*;
#(
  parameter int BP_HALF_CYC = 1_000_000, // clocks per backplane half-period
  parameter int STEP_HALVES = 80,        // half-periods per digit step (even)
  parameter int LED_HALVES  = 40         // half-periods per LED toggle
) (
  input  logic       clk_i,
  input  logic       rst_i,
  output logic       bp_o,
  output logic [6:0] seg_o,
  output logic       led_o
);
  logic   bp_tick, step_tick, led_tick;
  logic   bp_q, bp_d, led_q;
  digit_t digit_q, digit_d;
  seg_t   pat_d, seg_d, seg_q;

  // Divider chain: prescaler, then two counters of backplane half-periods.
  lcd_term_counter #(.TERM(BP_HALF_CYC)) u_pre (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(1'b1), .wrap_o(bp_tick));

  lcd_term_counter #(.TERM(STEP_HALVES)) u_step (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(bp_tick), .wrap_o(step_tick));

  lcd_term_counter #(.TERM(LED_HALVES)) u_led (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(bp_tick), .wrap_o(led_tick));

  assign bp_d    = bp_tick ? ~bp_q : bp_q;
  assign digit_d = step_tick ? digit_q + 1'b1 : digit_q;

  lcd_hex_encoder u_enc (.digit_i(digit_d), .pat_o(pat_d));

  // Per-segment XOR against the next backplane level.
  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    assign seg_d[s] = pat_d[s] ^ bp_d;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bp_q    <= 1'b0;
      led_q   <= 1'b0;
      digit_q <= '0;
      seg_q   <= SEG_AT_RESET;
    end else begin
      bp_q    <= bp_d;
      digit_q <= digit_d;
      seg_q   <= seg_d;
      if (led_tick) led_q <= ~led_q;
    end
  end

  assign bp_o  = bp_q;
  assign seg_o = seg_q;
  assign led_o = led_q;
endmodule

// File: rtl/lcd_hex_driver_chk.sv
module lcd_hex_driver_chk #(
  parameter int BP_HALF_CYC = 4
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       bp_o,
  input logic [6:0] seg_o,
  input logic       led_o
);
  localparam int GW = $clog2(BP_HALF_CYC + 2) + 1;
  localparam logic [GW-1:0] GMAX = '1;

  logic [GW-1:0] gap_q;
  logic          bp_seen_q;

  // Cycles since the backplane last changed, counted in the checker.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gap_q     <= '0;
      bp_seen_q <= 1'b0;
    end else begin
      bp_seen_q <= bp_o;
      if (bp_o != bp_seen_q) gap_q <= GW'(1);
      else if (gap_q != GMAX) gap_q <= gap_q + 1'b1;
    end
  end

  p_bp_half_period_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (bp_o != bp_seen_q) |-> (gap_q == GW'(BP_HALF_CYC)));

  p_full_flip_on_rise_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(bp_o) |-> (seg_o == ~$past(seg_o)));

  p_led_with_bp_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(led_o) |-> !$stable(bp_o));

  p_reset_values_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (bp_o == 1'b0 && led_o == 1'b0 && seg_o == 7'h3F));

  p_seg_with_bp_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(seg_o) |-> !$stable(bp_o));
endmodule

bind lcd_hex_driver lcd_hex_driver_chk #(.BP_HALF_CYC(BP_HALF_CYC)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .bp_o(bp_o), .seg_o(seg_o), .led_o(led_o));

// File: tb/test_lcd_hex_driver.sv
module test_lcd_hex_driver;
  localparam int CLK_PERIOD = 10;
  localparam int P = 3;  // clocks per backplane half-period
  localparam int S = 4;  // half-periods per digit step
  localparam int L = 2;  // half-periods per LED toggle

  // Expected active-high patterns for digits 0..F, bit 0 = a (R3).
  localparam logic [6:0] PAT [16] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
    7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bp_o, led_o;
  logic [6:0] seg_o;
  int n_chk = 0, n_fail = 0;
  int k = 0;
  logic prev_bp;
  logic [6:0] prev_seg;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_hex_driver #(.BP_HALF_CYC(P), .STEP_HALVES(S), .LED_HALVES(L)) i_lcd_hex_driver (
    .clk_i(clk), .rst_i(rst), .bp_o(bp_o), .seg_o(seg_o), .led_o(led_o));

  task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at k=%0d: actual %h expected %h", tag, k, act, exp);
    end
  endtask

  // Advance one clock and compare all outputs with the edge-count model.
  task automatic step_and_check();
    int h, d;
    logic ebp, eled;
    prev_bp = bp_o;
    prev_seg = seg_o;
    @(posedge clk);
    k++;
    @(negedge clk);
    h = k / P;
    ebp = 1'(h % 2);
    eled = 1'((h / L) % 2);
    d = (h / S) % 16;
    check("R1 backplane", {6'd0, bp_o}, {6'd0, ebp});
    check("R6 led", {6'd0, led_o}, {6'd0, eled});
    check("R2 R4 segments", seg_o, PAT[d] ^ {7{ebp}});
    if (seg_o !== prev_seg)
      check("R8 seg moves with bp", {6'd0, bp_o ^ prev_bp}, 7'd1);
    if ((k % (S*P)) == P)
      check($sformatf("R3 pattern of %h", d), seg_o ^ {7{bp_o}}, PAT[d]);
    if (k == 16*S*P)
      check("R5 wrap to 0", seg_o ^ {7{bp_o}}, PAT[0]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset bp", {6'd0, bp_o}, 7'd0);
    check("R7 reset led", {6'd0, led_o}, 7'd0);
    check("R7 reset seg", seg_o, 7'h3F);
    rst = 1'b0;
    k = 0;
    for (int i = 0; i < 17*S*P + 5; i++) step_and_check();

    // Reset in the middle of a run, then restart timing.
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7 mid-run reset bp", {6'd0, bp_o}, 7'd0);
    check("R7 mid-run reset led", {6'd0, led_o}, 7'd0);
    check("R7 mid-run reset seg", seg_o, 7'h3F);
    rst = 1'b0;
    k = 0;
    for (int i = 0; i < 3*S*P; i++) step_and_check();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule